// File: doc/BRIEF.md
# Serial Wire Debug Host: Line Reset and IDCODE Read

This block is a small host-side engine for a two-wire serial debug link. A start pulse wakes the target and reads its identification word. The engine runs the clock line, and it drives the bidirectional data line through a separate output value, an output enable and an input. After the read it reports the captured word and three error flags: a bad acknowledge, a bad parity bit, and a word that differs from a value supplied by the system.

The sequence starts with a line reset of `RST_BITS` high bits (default 53). The 16-bit switch pattern `0111100111100111` follows, then a second line reset and `IDLE_BITS` low idle bits. Then comes the identification read request `10100101`. Patterns are given in wire order, and the leftmost bit goes out first. The engine releases the data line right after the clock rising edge that samples the last request bit. It waits zero or one turnaround clocks, as `trn_one` selects, and then samples a 3-bit acknowledge. If the acknowledge is good, it samples 32 data bits and a parity bit. The engine then waits the same number of turnaround clocks, drives the line low for `TAIL_BITS` clocks and signals completion.

The clock line is made from the system clock. Each half of an SWCLK period lasts `half_period` system clocks, and a value of 0 is treated as 1. The states, in order, are `ST_IDLE`, `ST_LRST1`, `ST_SWITCH`, `ST_LRST2`, `ST_IDLEB`, `ST_REQ`, `ST_TRN1`, `ST_ACK`, `ST_DATA`, `ST_PAR`, `ST_TRN2`, `ST_TAIL` and `ST_FINISH`.

The transitions are as follows:
- `ST_IDLE` goes to `ST_LRST1` on `start`.
- Every other bit-carrying state moves to its successor on the falling SWCLK edge that ends its last bit.
- `ST_REQ` goes to `ST_TRN1` when `trn_one` is 1 and to `ST_ACK` when it is 0.
- `ST_ACK` goes to `ST_DATA` on a good acknowledge. On a bad acknowledge it goes to `ST_TRN2`, or to `ST_TAIL` when the turnaround is zero.
- `ST_PAR` goes to `ST_TRN2` or `ST_TAIL` in the same way.
- `ST_TAIL` goes to `ST_FINISH`, which returns to `ST_IDLE` after one system clock.

Top module: `swd_idcode_host`

## Requirements
- R1: After reset, and whenever the engine is idle, `busy`, `done`, `swclk` and `swdio_oe` are all 0.
- R2: While `swdio_oe` is 1, the host presents these bits in this order, one per SWCLK cycle, valid at each rising edge:
  - `RST_BITS` ones;
  - the pattern 0111100111100111, leftmost bit first;
  - `RST_BITS` ones;
  - `IDLE_BITS` zeros;
  - the request 10100101, leftmost bit first.
- R3: `swdio_out` changes only while SWCLK is low, and `swdio_oe` never rises while SWCLK is high.
- R4: `swdio_oe` drops to 0 in the high half of the rising edge that samples the last request bit. It drops before SWCLK falls again. The first acknowledge bit is sampled after a turnaround of `trn_one` (0 or 1) SWCLK cycles, and the host never drives while the target drives.
- R5: The acknowledge is 3 bits, and the first sampled bit is the LSB. Only the value 3'b001 continues the read. Any other value sets `ack_err`, skips the data phase, leaves `idcode` at 0, and gives a run of 143+2·`trn_one` SWCLK cycles with the default parameters.
- R6: On a good acknowledge, 32 data bits are captured into `idcode`, LSB first, followed by one parity bit. `parity_err` is 1 exactly when the XOR of the 32 data bits differs from that parity bit.
- R7: After a good acknowledge, `id_mismatch` is 1 exactly when `idcode` differs from `expected_id`. The customary expected value is 32'h2BA01477.
- R8: After the data phase, or after a bad acknowledge, the engine waits `trn_one` released cycles. It then drives the line low for `TAIL_BITS` clocks, and `done` then pulses for one system clock while `busy` is still 1. A full read lasts 176+2·`trn_one` SWCLK cycles with the default parameters.
- R9: Each SWCLK high phase lasts max(`half_period`,1) system clocks.
- R10: `start` is ignored while `busy` is 1. The result flags and `idcode` hold their values after `done` until the next accepted `start` clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a sequence when the engine is idle |
| half_period | input | DIV_W | SWCLK half-period in system clocks; 0 counts as 1 |
| trn_one | input | 1 | Turnaround length: 0 selects none, 1 selects one cycle |
| expected_id | input | DATA_W | Value the captured word is compared with |
| swclk | output | 1 | Debug clock to the target |
| swdio_out | output | 1 | Data value driven by the host |
| swdio_oe | output | 1 | Host output enable for the data line |
| swdio_in | input | 1 | Data line value seen by the host |
| busy | output | 1 | High from an accepted start through the done pulse |
| done | output | 1 | One-clock completion pulse |
| idcode | output | DATA_W | Captured identification word |
| ack_err | output | 1 | Acknowledge was not 3'b001 |
| parity_err | output | 1 | Parity bit disagreed with the data |
| id_mismatch | output | 1 | Captured word differs from expected_id |

## Verification
The hardest case to reach is the zero-turnaround handover. Here the host releases the line after the last request rising edge, and the target must drive the first acknowledge bit from the very next falling edge, so any off-by-one in the release or the sampling shows up only as a shifted acknowledge or as contention. The bench target model recognises the request in the bits the host drives, counts falling edges from the last request bit, and offsets its acknowledge, data and parity by the chosen turnaround. It checks for contention on every system clock. The vectors cover both turnaround settings and several divider values, including 0. They also supply a corrupted parity bit, a word that differs from the expected value, and two bad acknowledge codes, which reach the short path that skips the data phase.

// File: rtl/swd_pkg.sv
package swd_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LRST1,
        ST_SWITCH,
        ST_LRST2,
        ST_IDLEB,
        ST_REQ,
        ST_TRN1,
        ST_ACK,
        ST_DATA,
        ST_PAR,
        ST_TRN2,
        ST_TAIL,
        ST_FINISH
    } swd_state_e;

    // Wire order: bit 15 leaves first.
    localparam logic [15:0] SWITCH_SEQ     = 16'b0111100111100111;
    // Wire order: bit 7 leaves first.
    localparam logic [7:0]  REQ_IDCODE     = 8'b10100101;
    localparam logic [2:0]  ACK_OK         = 3'b001;
    localparam logic [31:0] IDCODE_DEFAULT = 32'h2BA01477;
    localparam int          SWITCH_LEN     = 16;
    localparam int          REQ_LEN        = 8;
    localparam int          ACK_LEN        = 3;
endpackage

// File: rtl/swd_clk_div.sv
module swd_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_period,
    output logic             swclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff;
    logic             tick;

    assign eff  = (half_period == '0) ? DIV_W'(1) : half_period;
    assign tick = run && (cnt_q == eff - DIV_W'(1));
    assign rise = tick && !swclk;
    assign fall = tick && swclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            swclk <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            swclk <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            swclk <= ~swclk;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/swd_rx_shift.sv
module swd_rx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         par_acc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word    <= '0;
            par_acc <= 1'b0;
        end else if (clear) begin
            word    <= '0;
            par_acc <= 1'b0;
        end else if (en) begin
            word    <= {din, word[W-1:1]};
            par_acc <= par_acc ^ din;
        end
    end
endmodule

// File: rtl/swd_idcode_host.sv
module swd_idcode_host
    import swd_pkg::*;
#(
    parameter int RST_BITS  = 53,
    parameter int IDLE_BITS = 2,
    parameter int TAIL_BITS = 8,
    parameter int DIV_W     = 8,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  half_period,
    input  logic              trn_one,
    input  logic [DATA_W-1:0] expected_id,
    output logic              swclk,
    output logic              swdio_out,
    output logic              swdio_oe,
    input  logic              swdio_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] idcode,
    output logic              ack_err,
    output logic              parity_err,
    output logic              id_mismatch
);
    localparam int MAXB  = (RST_BITS > DATA_W) ? RST_BITS : DATA_W;
    localparam int CNT_W = $clog2(MAXB + 1);

    swd_state_e       state, nxt, follow;
    logic [CNT_W-1:0] cnt;
    int               bit_len;
    logic             last, rise, fall, run, accept;
    logic             rel_q, trn_q, par_q, par_acc;
    logic [2:0]       ack_q;
    logic             ack_ok;
    logic [DIV_W-1:0] hp_q;

    assign accept = (state == ST_IDLE) && start;
    assign run    = (state != ST_IDLE) && (state != ST_FINISH);
    assign ack_ok = (ack_q == ACK_OK);

    swd_clk_div #(.DIV_W(DIV_W)) i_div (
        .clk(clk), .rst_n(rst_n), .run(run), .half_period(hp_q),
        .swclk(swclk), .rise(rise), .fall(fall)
    );

    swd_rx_shift #(.W(DATA_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .en(rise && (state == ST_DATA)), .din(swdio_in),
        .word(idcode), .par_acc(par_acc)
    );

    // Next-state logic
    always_comb begin
        bit_len = 1;
        follow  = ST_IDLE;
        unique case (state)
            ST_LRST1:  begin bit_len = RST_BITS;   follow = ST_SWITCH; end
            ST_SWITCH: begin bit_len = SWITCH_LEN; follow = ST_LRST2;  end
            ST_LRST2:  begin bit_len = RST_BITS;   follow = ST_IDLEB;  end
            ST_IDLEB:  begin bit_len = IDLE_BITS;  follow = ST_REQ;    end
            ST_REQ:    begin bit_len = REQ_LEN;    follow = trn_q ? ST_TRN1 : ST_ACK; end
            ST_TRN1:   begin bit_len = 1;          follow = ST_ACK;    end
            ST_ACK:    begin
                bit_len = ACK_LEN;
                follow  = ack_ok ? ST_DATA : (trn_q ? ST_TRN2 : ST_TAIL);
            end
            ST_DATA:   begin bit_len = DATA_W;     follow = ST_PAR;    end
            ST_PAR:    begin bit_len = 1;          follow = trn_q ? ST_TRN2 : ST_TAIL; end
            ST_TRN2:   begin bit_len = 1;          follow = ST_TAIL;   end
            ST_TAIL:   begin bit_len = TAIL_BITS;  follow = ST_FINISH; end
            default:   begin bit_len = 1;          follow = ST_IDLE;   end
        endcase
        last = (cnt == CNT_W'(bit_len - 1));
        nxt  = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_LRST1;
            ST_FINISH: nxt = ST_IDLE;
            default:   if (fall && last) nxt = follow;
        endcase
    end

    // State register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE || nxt != state) cnt <= '0;
            else if (fall)                        cnt <= cnt + 1'b1;
        end
    end

    // Line outputs decoded from state
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        swdio_oe  = 1'b0;
        swdio_out = 1'b0;
        unique case (state)
            ST_LRST1, ST_LRST2: begin swdio_oe = 1'b1; swdio_out = 1'b1; end
            ST_SWITCH: begin swdio_oe = 1'b1; swdio_out = SWITCH_SEQ[4'd15 - cnt[3:0]]; end
            ST_IDLEB:  begin swdio_oe = 1'b1; swdio_out = 1'b0; end
            ST_REQ:    begin swdio_oe = !rel_q; swdio_out = REQ_IDCODE[3'd7 - cnt[2:0]]; end
            ST_TAIL:   begin swdio_oe = 1'b1; swdio_out = 1'b0; end
            default:   ;
        endcase
    end

    // Capture and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_q <= 1'b0; trn_q <= 1'b0; par_q <= 1'b0; ack_q <= '0;
            hp_q <= '0; ack_err <= 1'b0; parity_err <= 1'b0; id_mismatch <= 1'b0;
        end else if (accept) begin
            rel_q <= 1'b0; trn_q <= trn_one; par_q <= 1'b0; ack_q <= '0;
            hp_q <= half_period; ack_err <= 1'b0; parity_err <= 1'b0; id_mismatch <= 1'b0;
        end else begin
            if (rise && state == ST_REQ && last) rel_q <= 1'b1;
            else if (fall)                       rel_q <= 1'b0;
            if (rise && state == ST_ACK) ack_q <= {swdio_in, ack_q[2:1]};
            if (rise && state == ST_PAR) par_q <= swdio_in;
            if (fall && state == ST_ACK && last && !ack_ok) ack_err <= 1'b1;
            if (fall && state == ST_PAR) begin
                parity_err  <= par_acc ^ par_q;
                id_mismatch <= (idcode != expected_id);
            end
        end
    end
endmodule

// File: rtl/swd_idcode_host_chk.sv
module swd_idcode_host_chk (
    input logic clk,
    input logic rst_n,
    input logic swclk,
    input logic swdio_out,
    input logic swdio_oe,
    input logic busy,
    input logic done,
    input logic ack_err,
    input logic parity_err,
    input logic id_mismatch
);
    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!swclk && !swdio_oe)); // R1

    AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (swclk && $past(swclk)) |-> $stable(swdio_out)); // R3

    AST_OE_NO_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (swclk && $past(swclk)) |-> !$rose(swdio_oe)); // R3

    AST_OE_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(swdio_oe) && !done) |-> swclk); // R4

    AST_ACKERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> (!parity_err && !id_mismatch)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R8
endmodule

bind swd_idcode_host swd_idcode_host_chk i_chk (
    .clk(clk), .rst_n(rst_n), .swclk(swclk), .swdio_out(swdio_out),
    .swdio_oe(swdio_oe), .busy(busy), .done(done), .ack_err(ack_err),
    .parity_err(parity_err), .id_mismatch(id_mismatch)
);

// File: tb/test_swd_idcode_host.sv
module test_swd_idcode_host;
    localparam int CLK_PERIOD = 10;
    localparam int RSTB = 53;
    localparam int IDLB = 2;
    localparam int HOST_BITS = RSTB + 16 + RSTB + IDLB + 8 + 8;
    localparam logic [15:0] SWP = 16'b0111100111100111;
    localparam logic [7:0]  RQP = 8'b10100101;

    typedef struct packed {
        logic        trn;
        logic [7:0]  hp;
        logic [2:0]  ack;
        logic        corrupt;
        logic [31:0] id;
        logic [31:0] expv;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 8'd1, 3'b001, 1'b0, 32'h2BA01477, 32'h2BA01477},
        '{1'b0, 8'd2, 3'b001, 1'b1, 32'h2BA01477, 32'h2BA01477},
        '{1'b0, 8'd1, 3'b001, 1'b0, 32'h0BB11477, 32'h2BA01477},
        '{1'b1, 8'd0, 3'b010, 1'b0, 32'h2BA01477, 32'h2BA01477},
        '{1'b1, 8'd3, 3'b001, 1'b0, 32'hFFFFFFFF, 32'h2BA01477},
        '{1'b0, 8'd1, 3'b100, 1'b0, 32'h2BA01477, 32'h2BA01477}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, trn_one = 1'b0;
    logic [7:0]  half_period = 8'd1;
    logic [31:0] expected_id = 32'h2BA01477;
    logic swclk, swdio_out, swdio_oe, swdio_in, busy, done;
    logic [31:0] idcode;
    logic ack_err, parity_err, id_mismatch;

    int checks = 0, failures = 0;

    // Target model state
    logic        prev_swclk = 1'b0, held_out = 1'b0, held_oe = 1'b0;
    logic        req_seen = 1'b0, tgt_en = 1'b0, tgt_bit = 1'b0, cfg_trn = 1'b0;
    logic [7:0]  req_sh = '0;
    logic [35:0] tgt_word = '0;
    int          tgt_n = 0, k = 0, rises = 0, host_n = 0, contention = 0;
    int          hi_run = 0, hi_max = 0, done_cnt = 0;
    logic        host_bits [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign swdio_in = swdio_oe ? swdio_out : (tgt_en ? tgt_bit : 1'b1);

    swd_idcode_host i_swd_idcode_host (
        .clk(clk), .rst_n(rst_n), .start(start), .half_period(half_period),
        .trn_one(trn_one), .expected_id(expected_id), .swclk(swclk),
        .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in),
        .busy(busy), .done(done), .idcode(idcode), .ack_err(ack_err),
        .parity_err(parity_err), .id_mismatch(id_mismatch)
    );

    always @(negedge clk) begin
        if (start && !busy) begin
            req_seen = 1'b0; tgt_en = 1'b0; req_sh = '0; k = 0; rises = 0;
            host_n = 0; contention = 0; hi_run = 0; hi_max = 0; done_cnt = 0;
        end else begin
            if (swclk && !prev_swclk) begin
                rises++;
                if (held_oe) begin
                    if (host_n < 256) host_bits[host_n] = held_out;
                    host_n++;
                    req_sh = {req_sh[6:0], held_out};
                    if (!req_seen && req_sh == RQP) begin
                        req_seen = 1'b1;
                        k = 0;
                    end
                end
            end
            if (!swclk && prev_swclk && req_seen) begin
                int j;
                k++;
                j = k - int'(cfg_trn) - 1;
                if (j >= 0 && j < tgt_n) begin
                    tgt_en = 1'b1;
                    tgt_bit = tgt_word[j];
                end else begin
                    tgt_en = 1'b0;
                end
            end
            if (swdio_oe && tgt_en) contention++;
            if (swclk) hi_run++;
            else begin
                if (hi_run > hi_max) hi_max = hi_run;
                hi_run = 0;
            end
            if (done) done_cnt++;
        end
        held_out = swdio_out;
        held_oe = swdio_oe;
        prev_swclk = swclk;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_host_bit(input int i);
        if (i < RSTB) return 1'b1;
        if (i < RSTB + 16) return SWP[15 - (i - RSTB)];
        if (i < 2*RSTB + 16) return 1'b1;
        if (i < 2*RSTB + 16 + IDLB) return 1'b0;
        if (i < 2*RSTB + 24 + IDLB) return RQP[7 - (i - 2*RSTB - 16 - IDLB)];
        return 1'b0;
    endfunction

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input bit extra_start);
        logic ok_ack, exp_par, exp_mis;
        logic [31:0] exp_id;
        int exp_rises, eff, t, bad_bits;
        ok_ack    = (v.ack == 3'b001);
        exp_par   = ok_ack && v.corrupt;
        exp_mis   = ok_ack && (v.id != v.expv);
        exp_id    = ok_ack ? v.id : 32'h0;
        exp_rises = ok_ack ? 176 + 2*int'(v.trn) : 143 + 2*int'(v.trn);
        eff       = (v.hp == 0) ? 1 : int'(v.hp);
        half_period = v.hp; trn_one = v.trn; expected_id = v.expv; cfg_trn = v.trn;
        tgt_word  = {(^v.id) ^ v.corrupt, v.id, v.ack};
        tgt_n     = ok_ack ? 36 : 3;
        pulse_start();
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
            if (extra_start && t == 100) pulse_start();
        end
        chk(done, "R8 done seen", 32'(done), 32'h1);
        chk(idcode == exp_id, ok_ack ? "R6 idcode" : "R5 idcode zero", idcode, exp_id);
        chk(ack_err == !ok_ack, "R5 ack_err", 32'(ack_err), 32'(!ok_ack));
        chk(parity_err == exp_par, "R6 parity_err", 32'(parity_err), 32'(exp_par));
        chk(id_mismatch == exp_mis, "R7 id_mismatch", 32'(id_mismatch), 32'(exp_mis));
        chk(rises == exp_rises, ok_ack ? "R8 swclk cycles" : "R5 swclk cycles",
            32'(rises), 32'(exp_rises));
        chk(contention == 0, "R4 no contention", 32'(contention), 32'h0);
        chk(hi_max == eff, "R9 high width", 32'(hi_max), 32'(eff));
        chk(host_n == HOST_BITS, "R2 host bit count", 32'(host_n), 32'(HOST_BITS));
        bad_bits = 0;
        for (int i = 0; i < HOST_BITS && i < host_n; i++)
            if (host_bits[i] !== exp_host_bit(i)) bad_bits++;
        chk(bad_bits == 0, "R2 host wire order", 32'(bad_bits), 32'h0);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1 && !busy, "R8 single done then idle", 32'(done_cnt), 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !swclk && !swdio_oe, "R1 reset state",
            {28'h0, busy, done, swclk, swdio_oe}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !swclk && !swdio_oe, "R1 idle after reset",
            {29'h0, busy, swclk, swdio_oe}, 32'h0);

        for (int i = 0; i < 6; i++) run_vec(VECS[i], 1'b0);

        // R10: start pulse while busy has no effect on the run
        run_vec(VECS[0], 1'b1);

        // R10: flags hold after done until the next accepted start
        run_vec(VECS[1], 1'b0);
        repeat (20) @(negedge clk);
        chk(parity_err == 1'b1, "R10 flag holds", 32'(parity_err), 32'h1);
        chk(idcode == 32'h2BA01477, "R10 idcode holds", idcode, 32'h2BA01477);
        half_period = 8'd1; trn_one = 1'b0; tgt_n = 36;
        tgt_word = {^32'h2BA01477, 32'h2BA01477, 3'b001};
        pulse_start();
        repeat (4) @(negedge clk);
        chk(parity_err == 1'b0 && idcode == 32'h0, "R10 cleared on start",
            {31'h0, parity_err}, 32'h0);
        begin
            int t = 0;
            while (!done && t < 20000) begin @(negedge clk); t++; end
        end
        chk(!parity_err && !ack_err && !id_mismatch, "R6 clean rerun",
            {29'h0, parity_err, ack_err, id_mismatch}, 32'h0);

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule